// File: doc/BRIEF.md
# RMII Receive Elasticity Buffer

This block sits on the receive path of a reduced-pin Ethernet PHY. Nibbles arrive in the recovered receive clock domain. The block emits 2-bit dibbles, together with combined carrier/data-valid, data-valid and error strobes, in the 50 MHz reference clock domain.

A small dual-clock FIFO absorbs the frequency offset between the two clocks. Read-out of a packet is held back until a programmable number of bits is buffered. The 2-bit threshold code is decoded differently at 100 Mb/s and at 10 Mb/s. At 10 Mb/s the reference clock runs ten times faster than the data, so each dibble is held for ten clocks.

The FIFO can fill up (overrun) or run dry (underrun) in the middle of a packet. When that happens, the rest of the packet is flagged with the error strobe and its data is inverted, so that the frame check sequence is sure to fail. A sticky flag records each kind of fault until it is read.

Top module: `rmii_rx_elastic`

## Requirements
- R1: After reset, crs_dv_o, rx_dv_o, rx_er_o, rxd_o, ovr_flag_o and udr_flag_o are all 0.
- R2: Each accepted nibble is emitted as two dibbles, bits [1:0] first and bits [3:2] second. Packet order is preserved.
- R3: At 100 Mb/s (speed_i=1), read-out starts once the buffered bits reach the threshold for thr_code_i: 01 gives 2 bits, 10 gives 6, 11 gives 10 and 00 gives 14.
- R4: At 10 Mb/s (speed_i=0), the threshold for thr_code_i is: 01 gives 8 bits, 10 gives 4, 11 gives 8 and 00 gives 12.
- R5: At 100 Mb/s a new dibble is presented on every reference clock. At 10 Mb/s each dibble is held for exactly 10 reference clocks.
- R6: crs_dv_o rises as soon as any packet data is buffered, even below the threshold. rx_dv_o is high only while dibbles are being presented, and it implies crs_dv_o.
- R7: A nibble that arrives with fewer than three free dibble slots is dropped. Every later dibble of that packet then carries rx_er_o=1 with inverted data. If nothing follows the drop, one error dibble is inserted before the end of the packet. ovr_flag_o is set.
- R8: If the FIFO is empty when a dibble is due inside a packet, a filler dibble 11 is emitted with rx_er_o=1. The rest of the packet carries rx_er_o=1 and inverted data, and udr_flag_o is set.
- R9: ovr_flag_o and udr_flag_o stay set until a cycle with stat_rd_i=1 clears them. A fault event in the same cycle as a clear wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Recovered receive clock (write side) |
| rclk_i | input | 1 | 50 MHz reference clock (read side) |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| speed_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| thr_code_i | input | 2 | Start threshold code |
| wr_dv_i | input | 1 | Packet active on the write side |
| wr_valid_i | input | 1 | wr_nib_i holds a nibble this write clock |
| wr_nib_i | input | 4 | Received nibble |
| stat_rd_i | input | 1 | Read strobe that clears the sticky flags |
| crs_dv_o | output | 1 | Carrier / data present |
| rx_dv_o | output | 1 | Dibble valid |
| rxd_o | output | 2 | Output dibble |
| rx_er_o | output | 1 | Receive error |
| ovr_flag_o | output | 1 | Sticky overrun flag |
| udr_flag_o | output | 1 | Sticky underrun flag |

## Verification
An underrun, which sets the sticky flag, can land in the same reference clock as a software clear of that flag. The bench provokes this by holding stat_rd_i high for the whole of a packet that starves in the middle, so every underrun cycle is also a clear cycle. It then judges that udr_flag_o was seen high at least once, because set must win over clear. It also checks that the errored, inverted tail of that packet still appears at the output.

// File: rtl/rxeb_pkg.sv
package rxeb_pkg;
  typedef enum logic {SPD_10 = 1'b0, SPD_100 = 1'b1} speed_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} rd_st_e;

  typedef struct packed {
    logic       eop;
    logic       bad;
    logic [1:0] d;
  } ent_t;

  // start threshold in bits; mapping is non-monotonic and speed dependent
  function automatic logic [3:0] thr_bits(speed_e spd, logic [1:0] code);
    logic [3:0] b;
    if (spd == SPD_100) begin
      case (code)
        2'b01:   b = 4'd2;
        2'b10:   b = 4'd6;
        2'b11:   b = 4'd10;
        default: b = 4'd14;
      endcase
    end else begin
      case (code)
        2'b01:   b = 4'd8;
        2'b10:   b = 4'd4;
        2'b11:   b = 4'd8;
        default: b = 4'd12;
      endcase
    end
    return b;
  endfunction
endpackage

// File: rtl/rxeb_sync.sv
module rxeb_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rxeb_wr.sv
module rxeb_wr
  import rxeb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          dv_i,
  input  logic          valid_i,
  input  logic [3:0]    nib_i,
  input  logic [AW:0]   rd_gray_i,
  output logic [AW:0]   wr_gray_o,
  output logic          ovr_tgl_o,
  input  logic [AW-1:0] raddr_i,
  output ent_t          rdata_o
);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  ent_t        mem [DEPTH];
  logic [AW:0] wr_bin_q, wr_bin_d, wr_gray_q;
  logic [AW:0] rd_gray_s, rd_bin_s, used, free;
  logic        in_pkt_q, bad_q, tgl_q;
  logic        do_data, do_ovr, do_eop;
  logic [AW-1:0] waddr0, waddr1;

  rxeb_sync #(.W(AW+1)) u_rd_sync (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rd_gray_i),
    .q_o   (rd_gray_s)
  );

  always_comb begin
    rd_bin_s = g2b(rd_gray_s);
    used     = wr_bin_q - rd_bin_s;
    free     = DEPTH_L - used;
    // one slot stays reserved for the end-of-packet marker
    do_data  = dv_i && valid_i && (free >= (AW+1)'(3));
    do_ovr   = dv_i && valid_i && (free <  (AW+1)'(3));
    do_eop   = !dv_i && in_pkt_q;
    wr_bin_d = wr_bin_q;
    if (do_data)     wr_bin_d = wr_bin_q + (AW+1)'(2);
    else if (do_eop) wr_bin_d = wr_bin_q + (AW+1)'(1);
    waddr0   = wr_bin_q[AW-1:0];
    waddr1   = wr_bin_q[AW-1:0] + AW'(1);
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bin_q  <= '0;
      wr_gray_q <= '0;
      in_pkt_q  <= 1'b0;
      bad_q     <= 1'b0;
      tgl_q     <= 1'b0;
    end else begin
      wr_bin_q  <= wr_bin_d;
      wr_gray_q <= wr_bin_d ^ (wr_bin_d >> 1);
      in_pkt_q  <= dv_i;
      if (do_eop)      bad_q <= 1'b0;
      else if (do_ovr) bad_q <= 1'b1;
      if (do_ovr) tgl_q <= ~tgl_q;
    end
  end

  always_ff @(posedge wclk_i) begin
    if (do_data) begin
      mem[waddr0] <= '{eop: 1'b0, bad: bad_q, d: nib_i[1:0]};
      mem[waddr1] <= '{eop: 1'b0, bad: bad_q, d: nib_i[3:2]};
    end else if (do_eop) begin
      mem[waddr0] <= '{eop: 1'b1, bad: bad_q, d: 2'b00};
    end
  end

  assign rdata_o   = mem[raddr_i];
  assign wr_gray_o = wr_gray_q;
  assign ovr_tgl_o = tgl_q;

  a_r7_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    used <= DEPTH_L);
  a_r7_marker_room: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    do_eop |-> free != '0);
endmodule

// File: rtl/rxeb_rd.sv
module rxeb_rd
  import rxeb_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int AW       = 4,
  parameter int SLOW_DIV = 10
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          speed_i,
  input  logic [1:0]    thr_code_i,
  input  logic [AW:0]   wr_gray_i,
  output logic [AW:0]   rd_gray_o,
  output logic [AW-1:0] raddr_o,
  input  ent_t          rdata_i,
  output logic          udr_evt_o,
  output logic          crs_dv_o,
  output logic          rx_dv_o,
  output logic [1:0]    rxd_o,
  output logic          rx_er_o
);
  localparam int          PW      = $clog2(SLOW_DIV);
  localparam logic [PW-1:0] PACE_LAST = PW'(SLOW_DIV - 1);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  speed_e      spd;
  rd_st_e      st_q;
  logic [AW:0] wr_gray_s, wr_bin_s, rd_bin_q, rd_bin_d, rd_gray_q, level, thr_d;
  logic [PW-1:0] pace_q;
  logic        tick, empty, pop, corrupt_q, flag_eop_err;
  logic [3:0]  thr_b;

  rxeb_sync #(.W(AW+1)) u_wr_sync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wr_gray_i),
    .q_o   (wr_gray_s)
  );

  always_comb begin
    spd      = speed_e'(speed_i);
    thr_b    = thr_bits(spd, thr_code_i);
    thr_d    = (AW+1)'(thr_b >> 1);
    wr_bin_s = g2b(wr_gray_s);
    level    = wr_bin_s - rd_bin_q;
    empty    = (level == '0);
    tick     = (spd == SPD_100) || (pace_q == '0);
    // dropped tail with no later data: insert one error dibble before ending
    flag_eop_err = rdata_i.eop && rdata_i.bad && !corrupt_q;
    pop      = (st_q == ST_RUN) && tick && !empty && !flag_eop_err;
    udr_evt_o = (st_q == ST_RUN) && tick && empty;
    rd_bin_d = rd_bin_q + (pop ? (AW+1)'(1) : (AW+1)'(0));
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      rd_bin_q  <= '0;
      rd_gray_q <= '0;
      pace_q    <= '0;
      corrupt_q <= 1'b0;
      crs_dv_o  <= 1'b0;
      rx_dv_o   <= 1'b0;
      rxd_o     <= 2'b00;
      rx_er_o   <= 1'b0;
    end else begin
      rd_bin_q  <= rd_bin_d;
      rd_gray_q <= rd_bin_d ^ (rd_bin_d >> 1);
      if (st_q == ST_IDLE) begin
        crs_dv_o  <= !empty;
        rx_dv_o   <= 1'b0;
        rx_er_o   <= 1'b0;
        rxd_o     <= 2'b00;
        corrupt_q <= 1'b0;
        pace_q    <= '0;
        if (!empty && level >= thr_d) st_q <= ST_RUN;
      end else begin
        if (spd == SPD_10) pace_q <= (pace_q == PACE_LAST) ? '0 : pace_q + PW'(1);
        else               pace_q <= '0;
        if (tick) begin
          if (empty || flag_eop_err) begin
            corrupt_q <= 1'b1;
            crs_dv_o  <= 1'b1;
            rx_dv_o   <= 1'b1;
            rxd_o     <= 2'b11;
            rx_er_o   <= 1'b1;
          end else if (rdata_i.eop) begin
            st_q      <= ST_IDLE;
            corrupt_q <= 1'b0;
            crs_dv_o  <= (level > (AW+1)'(1));
            rx_dv_o   <= 1'b0;
            rxd_o     <= 2'b00;
            rx_er_o   <= 1'b0;
          end else begin
            crs_dv_o  <= 1'b1;
            rx_dv_o   <= 1'b1;
            rx_er_o   <= corrupt_q | rdata_i.bad;
            rxd_o     <= (corrupt_q | rdata_i.bad) ? ~rdata_i.d : rdata_i.d;
            if (rdata_i.bad) corrupt_q <= 1'b1;
          end
        end
      end
    end
  end

  assign rd_gray_o = rd_gray_q;
  assign raddr_o   = rd_bin_q[AW-1:0];

  a_r6_dv_implies_crs: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rx_dv_o |-> crs_dv_o);
  a_r8_level_bound: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    level <= DEPTH_L);
  a_r5_slow_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && spd == SPD_10 && pace_q != '0 && $stable(speed_i)) |=> $stable(rxd_o));
  a_r8_corrupt_err: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && tick && corrupt_q && !rdata_i.eop) |=> rx_er_o);
endmodule

// File: rtl/rxeb_flags.sv
module rxeb_flags (
  input  logic rclk_i,
  input  logic rst_ni,
  input  logic ovr_tgl_i,
  input  logic udr_evt_i,
  input  logic clr_i,
  output logic ovr_o,
  output logic udr_o
);
  logic ovr_s, ovr_prev_q, ovr_evt;

  rxeb_sync #(.W(1)) u_tgl_sync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (ovr_tgl_i),
    .q_o   (ovr_s)
  );

  assign ovr_evt = ovr_s ^ ovr_prev_q;

  // a new event outranks a clear in the same cycle
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_prev_q <= 1'b0;
      ovr_o      <= 1'b0;
      udr_o      <= 1'b0;
    end else begin
      ovr_prev_q <= ovr_s;
      ovr_o      <= ovr_evt   | (ovr_o & ~clr_i);
      udr_o      <= udr_evt_i | (udr_o & ~clr_i);
    end
  end

  a_r9_set_wins: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    udr_evt_i |=> udr_o);
  a_r9_udr_sticky: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (udr_o && !clr_i) |=> udr_o);
  a_r9_ovr_sticky: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ovr_o && !clr_i) |=> ovr_o);
endmodule

// File: rtl/rmii_rx_elastic.sv
module rmii_rx_elastic
  import rxeb_pkg::*;
#(
  parameter int FIFO_BITS = 32,
  parameter int SLOW_DIV  = 10
) (
  input  logic       wclk_i,
  input  logic       rclk_i,
  input  logic       rst_ni,
  input  logic       speed_i,
  input  logic [1:0] thr_code_i,
  input  logic       wr_dv_i,
  input  logic       wr_valid_i,
  input  logic [3:0] wr_nib_i,
  input  logic       stat_rd_i,
  output logic       crs_dv_o,
  output logic       rx_dv_o,
  output logic [1:0] rxd_o,
  output logic       rx_er_o,
  output logic       ovr_flag_o,
  output logic       udr_flag_o
);
  localparam int DEPTH = FIFO_BITS / 2;
  localparam int AW    = $clog2(DEPTH);

  logic [AW:0]   wr_gray, rd_gray;
  logic [AW-1:0] raddr;
  ent_t          rdata;
  logic          ovr_tgl, udr_evt;

  rxeb_wr #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .wclk_i   (wclk_i),
    .rst_ni   (rst_ni),
    .dv_i     (wr_dv_i),
    .valid_i  (wr_valid_i),
    .nib_i    (wr_nib_i),
    .rd_gray_i(rd_gray),
    .wr_gray_o(wr_gray),
    .ovr_tgl_o(ovr_tgl),
    .raddr_i  (raddr),
    .rdata_o  (rdata)
  );

  rxeb_rd #(.DEPTH(DEPTH), .AW(AW), .SLOW_DIV(SLOW_DIV)) u_rd (
    .rclk_i    (rclk_i),
    .rst_ni    (rst_ni),
    .speed_i   (speed_i),
    .thr_code_i(thr_code_i),
    .wr_gray_i (wr_gray),
    .rd_gray_o (rd_gray),
    .raddr_o   (raddr),
    .rdata_i   (rdata),
    .udr_evt_o (udr_evt),
    .crs_dv_o  (crs_dv_o),
    .rx_dv_o   (rx_dv_o),
    .rxd_o     (rxd_o),
    .rx_er_o   (rx_er_o)
  );

  rxeb_flags u_flags (
    .rclk_i   (rclk_i),
    .rst_ni   (rst_ni),
    .ovr_tgl_i(ovr_tgl),
    .udr_evt_i(udr_evt),
    .clr_i    (stat_rd_i),
    .ovr_o    (ovr_flag_o),
    .udr_o    (udr_flag_o)
  );
endmodule

// File: tb/rmii_rx_elastic_tb.sv
`timescale 1ns/1ps
module rmii_rx_elastic_tb;
  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic       spd = 1'b1, wdv = 1'b0, wval = 1'b0, srd = 1'b0;
  logic [1:0] code = 2'b01;
  logic [3:0] nib = 4'h0;
  logic       crs_dv, rx_dv, rx_er, ovr_f, udr_f;
  logic [1:0] rxd;
  real        whalf = 4.0;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2 rclk = ~rclk;
  always #(whalf) wclk = ~wclk;

  rmii_rx_elastic u_dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .speed_i(spd),
    .thr_code_i(code), .wr_dv_i(wdv), .wr_valid_i(wval), .wr_nib_i(nib),
    .stat_rd_i(srd), .crs_dv_o(crs_dv), .rx_dv_o(rx_dv), .rxd_o(rxd),
    .rx_er_o(rx_er), .ovr_flag_o(ovr_f), .udr_flag_o(udr_f)
  );

  // {speed, code, nibbles that stay below threshold}
  localparam logic [5:0] VEC [8] = '{
    6'b1_01_000, 6'b1_10_001, 6'b1_11_010, 6'b1_00_011,
    6'b0_01_001, 6'b0_10_000, 6'b0_11_001, 6'b0_00_010
  };

  // output monitor
  logic [1:0] cap [256];
  int  cap_n, dv_clks, hold, er_drop;
  bit  er_seen, udr_seen, mon_rst = 1'b1;
  always @(negedge rclk) begin
    if (mon_rst) begin
      cap_n = 0; dv_clks = 0; hold = 0; er_drop = 0; er_seen = 0; udr_seen = 0;
    end else begin
      if (udr_f) udr_seen = 1;
      if (rx_dv) begin
        dv_clks++;
        if (hold == 0) begin
          if (cap_n < 256) cap[cap_n] = rxd;
          cap_n++;
          if (rx_er) er_seen = 1;
          else if (er_seen) er_drop++;
        end
        if (!spd) hold = (hold == 9) ? 0 : hold + 1;
        else hold = 0;
      end else hold = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wdv = 1'b1; wval = 1'b1; nib = 4'(base + i);
    end
    @(negedge wclk);
    wval = 1'b0;
  endtask

  task automatic end_pkt();
    @(negedge wclk);
    wdv = 1'b0; wval = 1'b0;
  endtask

  task automatic rwait(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic clr_flags();
    @(negedge rclk); srd = 1'b1;
    @(negedge rclk); srd = 1'b0;
    rwait(3);
  endtask

  task automatic mon_clear();
    @(negedge rclk); mon_rst = 1'b1;
    @(negedge rclk); mon_rst = 1'b0;
  endtask

  function automatic logic [1:0] exp_dib(input int base, input int k);
    logic [3:0] v;
    v = 4'(base + k / 2);
    return (k % 2 == 1) ? v[3:2] : v[1:0];
  endfunction

  initial begin
    #(800000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int mism;
    bit found;
    #10;
    chk("R1 out", int'({crs_dv, rx_dv, rx_er, rxd}), 0);
    chk("R1 flags", int'({ovr_f, udr_f}), 0);
    #10 rst_n = 1'b1;
    rwait(5);
    chk("R1 after release", int'({crs_dv, rx_dv, rx_er, rxd, ovr_f, udr_f}), 0);

    // threshold table: below threshold no read-out, one nibble more starts it
    for (int r = 0; r < 8; r++) begin
      spd = VEC[r][5]; code = VEC[r][4:3];
      whalf = spd ? 4.0 : 40.0;
      rwait(30);
      send(int'(VEC[r][2:0]), 1);
      rwait(40);
      chk(spd ? "R3 below" : "R4 below", int'(rx_dv), 0);
      chk("R6 crs early", int'(crs_dv), int'(VEC[r][2:0] != 0));
      send(1, 7);
      rwait(40);
      chk(spd ? "R3 start" : "R4 start", int'(rx_dv), 1);
      end_pkt();
      rwait(120);
      clr_flags();
    end

    // R2 / R5 100 Mb/s clean packet
    spd = 1'b1; code = 2'b00; whalf = 4.0;
    rwait(20); mon_clear();
    send(24, 3); end_pkt();
    rwait(200);
    mism = 0;
    for (int k = 0; k < 48; k++) if (cap[k] !== exp_dib(3, k)) mism++;
    chk("R2 count 100M", cap_n, 48);
    chk("R2 data 100M", mism, 0);
    chk("R5 one per clk", dv_clks, 48);
    chk("R8 no err clean", int'(er_seen), 0);
    chk("R8 no udr clean", int'({ovr_f, udr_f}), 0);

    // R2 / R5 10 Mb/s clean packet
    spd = 1'b0; code = 2'b00; whalf = 40.0;
    rwait(20); mon_clear();
    send(8, 9); end_pkt();
    rwait(600);
    mism = 0;
    for (int k = 0; k < 16; k++) if (cap[k] !== exp_dib(9, k)) mism++;
    chk("R2 count 10M", cap_n, 16);
    chk("R2 data 10M", mism, 0);
    chk("R5 hold ten", dv_clks, 160);
    clr_flags();

    // R7 overrun: write twice as fast as read
    spd = 1'b1; code = 2'b01; whalf = 1.8;
    rwait(20); mon_clear();
    send(40, 0); end_pkt();
    rwait(300);
    chk("R7 rx_er seen", int'(er_seen), 1);
    chk("R7 err kept", er_drop, 0);
    chk("R7 ovr flag", int'(ovr_f), 1);
    chk("R7 no udr", int'(udr_f), 0);
    clr_flags();
    chk("R9 cleared", int'({ovr_f, udr_f}), 0);

    // R8 underrun with clear held high the whole time (R9 set wins)
    whalf = 4.0;
    rwait(20); mon_clear();
    @(negedge rclk); srd = 1'b1;
    send(2, 1);
    rwait(30);
    @(negedge wclk); nib = 4'h9; wval = 1'b1;
    @(negedge wclk); nib = 4'hC;
    @(negedge wclk); wval = 1'b0;
    end_pkt();
    rwait(60);
    found = 0;
    for (int k = 0; k + 3 < cap_n && k + 3 < 256; k++)
      if (cap[k] == 2'b10 && cap[k+1] == 2'b01 && cap[k+2] == 2'b11 && cap[k+3] == 2'b00)
        found = 1;
    chk("R8 rx_er seen", int'(er_seen), 1);
    chk("R8 err kept", er_drop, 0);
    chk("R8 inverted tail", int'(found), 1);
    chk("R9 set wins", int'(udr_seen), 1);
    @(negedge rclk); srd = 1'b0;
    rwait(3);
    chk("R9 clear held", int'(udr_f), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule